// File: doc/BRIEF.md
# Triangle Ramp Servo Generator

This block produces the per-row feedback value for a servo loop that runs in ramp mode. For every row it takes the word stored for that row in the previous pass. It works out the next value and the next direction of travel, and hands a 40-bit word plus a one-cycle write strobe to the external per-row queue. The values trace a triangle: they climb from zero in fixed steps up to a programmed peak, fall back to zero in the same steps, and repeat.

The climb is slowed by a hold counter. The counter counts frame-start pulses and marks one frame out of every `hold_frames_i + 1` frames as an update frame. Rows processed outside an update frame write back their previous word unchanged, so the output holds level for the programmed number of frames. An initialize window restarts the ramp. Every row processed during that window is written as zero with the direction set to climb, and the hold counter is cleared. Frame timing and the queue memory are outside the block.

Top module: `ramp_servo_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `wr_stb_o` is 0 and `wr_word_o` is all zeros.
- R2: The servo mode field is decoded as 2'b10 = ramp, 2'b01 = constant, 2'b11 = lock and 2'b00 = invalid. Only 2'b10 produces a write strobe. A row slot under any other code leaves `wr_stb_o` low.
- R3: A row slot in ramp mode gives exactly one strobe cycle, in the clock cycle after the slot, with the word valid in that same cycle.
- R4: Word layout: bit 39 is the direction (0 = climb, 1 = descend), bits 15..0 are the ramp value, and bits 38..16 are always zero.
- R5: In an update frame, a climbing row whose value plus step stays below the peak is written as value + step, with direction 0.
- R6: In an update frame, a climbing row whose value plus step reaches or passes the peak is written as exactly the peak, with direction 1.
- R7: In an update frame, a descending row whose value is greater than the step is written as value − step with direction 1. Otherwise it is written as 0 with direction 0.
- R8: A ramp-mode row slot outside an update frame and outside the initialize window writes back the previous word bit for bit.
- R9: Let N be the value of `hold_frames_i`. After the initialize window, the (N+1)-th frame-start pulse begins an update frame, and every (N+1)-th pulse after that does the same. The update state lasts until the next frame-start pulse.
- R10: A ramp-mode row slot while `init_win_i` is high writes the all-zero word, whatever the previous word was. The window also clears the hold counter and any pending update frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| servo_mode_i | input | 2 | Servo mode code |
| step_i | input | 16 | Ramp step size |
| peak_i | input | 16 | Ramp peak amplitude |
| hold_frames_i | input | HOLD_W | Frames to hold between updates |
| init_win_i | input | 1 | Initialize window (level) |
| frame_start_i | input | 1 | One-cycle pulse at each frame start |
| row_slot_i | input | 1 | One-cycle pulse for each row's processing slot |
| prev_word_i | input | 40 | Stored word for the current row |
| wr_word_o | output | 40 | Word to write into the row queue |
| wr_stb_o | output | 1 | One-cycle queue write strobe |

## Verification
The assertions assume three things about the inputs. The stored word offered on `prev_word_i` was written earlier by this block, so its padding bits are zero and its value lies at or below the peak. Step, peak and hold count do not change while rows are being processed. Row slots never coincide with frame-start pulses. The stimulus keeps to these rules by feeding each row's previous word from a bench model of the queue, which starts from the all-zero word after an initialize window. It changes settings only inside idle gaps or initialize windows, and it always places a frame-start pulse in a cycle of its own before that frame's row slots.

// File: rtl/ramp_gen_pkg.sv
package ramp_gen_pkg;

    localparam int RAMP_VAL_W  = 16;
    localparam int RAMP_WORD_W = 40;
    localparam int RAMP_PAD_W  = RAMP_WORD_W - 1 - RAMP_VAL_W;

    typedef enum logic [1:0] {
        SERVO_OFF   = 2'b00,
        SERVO_CONST = 2'b01,
        SERVO_RAMP  = 2'b10,
        SERVO_LOCK  = 2'b11
    } servo_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } ramp_dir_e;

    typedef struct packed {
        ramp_dir_e               dir;
        logic [RAMP_VAL_W-1:0]   val;
    } ramp_state_t;

    function automatic logic [RAMP_WORD_W-1:0] ramp_pack(input ramp_state_t s);
        return {s.dir, {RAMP_PAD_W{1'b0}}, s.val};
    endfunction

    function automatic ramp_state_t ramp_unpack(input logic [RAMP_WORD_W-1:0] w);
        ramp_state_t s;
        s.dir = ramp_dir_e'(w[RAMP_WORD_W-1]);
        s.val = w[RAMP_VAL_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/ramp_step_calc.sv
module ramp_step_calc
    import ramp_gen_pkg::*;
(
    input  ramp_state_t            cur_i,
    input  logic [RAMP_VAL_W-1:0]  step_i,
    input  logic [RAMP_VAL_W-1:0]  peak_i,
    output ramp_state_t            nxt_o
);

    logic [RAMP_VAL_W:0]   up_sum;
    logic [RAMP_VAL_W-1:0] dn_diff;

    assign up_sum  = {1'b0, cur_i.val} + {1'b0, step_i};
    assign dn_diff = cur_i.val - step_i;

    always_comb begin
        nxt_o = cur_i;
        if (cur_i.dir == DIR_UP) begin
            if (up_sum >= {1'b0, peak_i}) begin
                nxt_o.val = peak_i;
                nxt_o.dir = DIR_DOWN;
            end else begin
                nxt_o.val = up_sum[RAMP_VAL_W-1:0];
                nxt_o.dir = DIR_UP;
            end
        end else begin
            if (cur_i.val <= step_i) begin
                nxt_o.val = '0;
                nxt_o.dir = DIR_UP;
            end else begin
                nxt_o.val = dn_diff;
                nxt_o.dir = DIR_DOWN;
            end
        end
    end

endmodule

// File: rtl/ramp_hold_ctr.sv
module ramp_hold_ctr #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_win_i,
    input  logic              frame_start_i,
    input  logic [HOLD_W-1:0] hold_frames_i,
    output logic              upd_o
);

    logic [HOLD_W-1:0] frame_cnt;

    always_ff @(posedge clk) begin
        if (rst || init_win_i) begin
            frame_cnt <= '0;
            upd_o     <= 1'b0;
        end else if (frame_start_i) begin
            if (frame_cnt >= hold_frames_i) begin
                frame_cnt <= '0;
                upd_o     <= 1'b1;
            end else begin
                frame_cnt <= frame_cnt + 1'b1;
                upd_o     <= 1'b0;
            end
        end
    end

    // R9
    upd_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(upd_o) |-> $past(frame_start_i));

    // R10
    init_clears_upd_chk: assert property (@(posedge clk) disable iff (rst)
        $past(init_win_i) |-> !upd_o);

endmodule

// File: rtl/ramp_servo_gen.sv
module ramp_servo_gen
    import ramp_gen_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              servo_mode_i,
    input  logic [RAMP_VAL_W-1:0]   step_i,
    input  logic [RAMP_VAL_W-1:0]   peak_i,
    input  logic [HOLD_W-1:0]       hold_frames_i,
    input  logic                    init_win_i,
    input  logic                    frame_start_i,
    input  logic                    row_slot_i,
    input  logic [RAMP_WORD_W-1:0]  prev_word_i,
    output logic [RAMP_WORD_W-1:0]  wr_word_o,
    output logic                    wr_stb_o
);

    servo_mode_e mode;
    ramp_state_t cur_st;
    ramp_state_t nxt_st;
    ramp_state_t sel_st;
    logic        upd;
    logic        ramp_slot;

    assign mode      = servo_mode_e'(servo_mode_i);
    assign cur_st    = ramp_unpack(prev_word_i);
    assign ramp_slot = row_slot_i && (mode == SERVO_RAMP);

    ramp_hold_ctr #(.HOLD_W(HOLD_W)) u_hold (
        .clk           (clk),
        .rst           (rst),
        .init_win_i    (init_win_i),
        .frame_start_i (frame_start_i),
        .hold_frames_i (hold_frames_i),
        .upd_o         (upd)
    );

    ramp_step_calc u_calc (
        .cur_i  (cur_st),
        .step_i (step_i),
        .peak_i (peak_i),
        .nxt_o  (nxt_st)
    );

    always_comb begin
        if (init_win_i) begin
            sel_st.dir = DIR_UP;
            sel_st.val = '0;
        end else if (upd) begin
            sel_st = nxt_st;
        end else begin
            sel_st = cur_st;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_word_o <= '0;
            wr_stb_o  <= 1'b0;
        end else begin
            wr_stb_o <= ramp_slot;
            if (ramp_slot) begin
                wr_word_o <= ramp_pack(sel_st);
            end
        end
    end

    // R2
    mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> ($past(servo_mode_i) == 2'b10));

    // R3
    slot_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> $past(row_slot_i));

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> (wr_word_o[RAMP_WORD_W-2:RAMP_VAL_W] == '0));

    // R6
    peak_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o && !$past(init_win_i) &&
         ($past(prev_word_i[RAMP_VAL_W-1:0]) <= $past(peak_i)))
        |-> (wr_word_o[RAMP_VAL_W-1:0] <= $past(peak_i)));

    // R8
    hold_level_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o && !$past(init_win_i) && !$past(upd))
        |-> (wr_word_o == $past(prev_word_i)));

    // R10
    init_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o && $past(init_win_i)) |-> (wr_word_o == '0));

endmodule

// File: tb/sim_ramp_servo_gen.sv
module sim_ramp_servo_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 4;
    localparam int HW         = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  servo_mode_i;
    logic [15:0] step_i, peak_i;
    logic [HW-1:0] hold_frames_i;
    logic        init_win_i, frame_start_i, row_slot_i;
    logic [39:0] prev_word_i;
    logic [39:0] wr_word_o;
    logic        wr_stb_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [39:0] mem [NROWS];
    int  m_cnt;
    bit  m_upd;
    bit  exp_stb;
    logic [39:0] exp_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    ramp_servo_gen #(.HOLD_W(HW)) u0 (
        .clk(clk), .rst(rst), .servo_mode_i(servo_mode_i), .step_i(step_i),
        .peak_i(peak_i), .hold_frames_i(hold_frames_i), .init_win_i(init_win_i),
        .frame_start_i(frame_start_i), .row_slot_i(row_slot_i),
        .prev_word_i(prev_word_i), .wr_word_o(wr_word_o), .wr_stb_o(wr_stb_o)
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] model_next(input logic [39:0] w);
        int v, s, p;
        bit d;
        logic [15:0] vv;
        v = int'(w[15:0]); d = w[39]; s = int'(step_i); p = int'(peak_i);
        if (!d) begin
            if (v + s >= p) begin v = p; d = 1; end
            else v = v + s;
        end else begin
            if (v <= s) begin v = 0; d = 0; end
            else v = v - s;
        end
        vv = v[15:0];
        return {d, 23'b0, vv};
    endfunction

    task automatic cyc(input bit fs, input bit rs, input int row, input string tag);
        logic [39:0] w;
        frame_start_i = fs;
        row_slot_i    = rs;
        prev_word_i   = mem[row];
        if (rs && servo_mode_i == 2'b10) begin
            if (init_win_i)  w = '0;
            else if (m_upd)  w = model_next(mem[row]);
            else             w = mem[row];
            exp_stb  = 1;
            exp_word = w;
            mem[row] = w;
        end else begin
            exp_stb = 0;
        end
        if (init_win_i) begin
            m_cnt = 0; m_upd = 0;
        end else if (fs) begin
            if (m_cnt >= int'(hold_frames_i)) begin m_cnt = 0; m_upd = 1; end
            else begin m_cnt++; m_upd = 0; end
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R3 strobe"}, {39'b0, wr_stb_o}, {39'b0, exp_stb});
        if (exp_stb) begin
            chk({tag, " word"}, wr_word_o, exp_word);
            chk("R4 padding", {16'b0, wr_word_o[38:16]}, 40'b0);
        end
        frame_start_i = 0;
        row_slot_i    = 0;
    endtask

    task automatic frame(input string tag);
        cyc(1, 0, 0, tag);
        for (int r = 0; r < NROWS; r++) begin
            cyc(0, 1, r, tag);
            cyc(0, 0, 0, tag);
        end
    endtask

    task automatic init_window();
        init_win_i = 1;
        for (int r = 0; r < NROWS; r++) cyc(0, 1, r, "R10 init");
        cyc(1, 0, 0, "R10 init");
        init_win_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; servo_mode_i = 2'b10; step_i = 16'd5; peak_i = 16'd17;
        hold_frames_i = '0; init_win_i = 0; frame_start_i = 0; row_slot_i = 0;
        prev_word_i = '0; m_cnt = 0; m_upd = 0; exp_stb = 0; exp_word = '0;
        for (int r = 0; r < NROWS; r++) mem[r] = {1'b1, 23'b0, 16'(r * 3 + 1)};
        repeat (3) @(negedge clk);
        chk("R1 reset strobe", {39'b0, wr_stb_o}, 40'b0);
        chk("R1 reset word", wr_word_o, 40'b0);
        rst = 0;
        @(negedge clk);
        chk("R1 after release strobe", {39'b0, wr_stb_o}, 40'b0);
        chk("R1 after release word", wr_word_o, 40'b0);

        // R10: junk previous words cleared by initialize window
        init_window();
        // R5 R6 R7: triangle with overshoot clamp, hold 0
        for (int f = 0; f < 12; f++) frame("R5/R6/R7 ramp");

        // R6 R7 exact hits on peak and zero
        step_i = 16'd4; peak_i = 16'd12;
        init_window();
        for (int f = 0; f < 8; f++) frame("R6/R7 exact");

        // R8 R9: hold for two frames between updates
        hold_frames_i = 8'd2; step_i = 16'd3; peak_i = 16'd9;
        init_window();
        for (int f = 0; f < 10; f++) frame("R8/R9 hold");

        // R2: non-ramp codes give no strobe
        servo_mode_i = 2'b01; frame("R2 const");
        servo_mode_i = 2'b11; frame("R2 lock");
        servo_mode_i = 2'b00; frame("R2 invalid");
        servo_mode_i = 2'b10;
        for (int f = 0; f < 3; f++) frame("R8/R9 resume");

        // R10 mid-ramp restart
        init_window();
        for (int f = 0; f < 2; f++) frame("R10 restart");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule